// File: doc/BRIEF.md
# Queued-Sample Pulse-Width Modulator

This block is a single-channel pulse-width modulator that sits behind a small word-addressed register port. Software queues duty values in a short sample queue, programs a period and a clock divider, and sets the enable bit. The divided clock advances a counter through one period. While the counter is below the current sample, the output is active. At each wrap the block either repeats the current sample or takes the next one from the queue.

The output can be driven normally, inverted, or held off. A self-clearing soft reset returns every register and the queue to zero. Sticky status flags report the queue level, writes that overflowed the queue, a queue that ran dry, counter wraps and compare matches. The clock-source and low-power control bits are only stored and read back.

Top module: `fifo_pwm`

## Requirements
- R1: Word registers are decoded from byte addresses: control 0x00, status 0x04, sample 0x0C, period 0x10. Control keeps bits [27:0] other than bit 3 for read-back. Period keeps 16 bits. Any other or unaligned address reads 0, and writes to it have no effect.
- R2: One output period lasts period+2 prescaled ticks, with the counter running from 0 to period+1 and then wrapping to 0. A period value of 0xffff gives the same period as 0xfffe.
- R3: Control bits [15:4] hold the divider minus one. The counter advances once every field+1 clocks, so a field of 0 advances it on every clock.
- R4: Control bits [19:18] select the output. 0 drives 1 while count < sample. 1 drives the complement of that while running. 2 and 3 hold the output at 0.
- R5: Control bits [2:1] set how many periods each sample is used (1, 2, 4 or 8) before the next queue entry is taken.
- R6: Writing 1 to control bit 3 clears all registers, flags, the queue and the current sample. Bit 3 then reads 1 for 3 clocks. Register writes are ignored during those clocks, and afterwards the bit reads 0.
- R7: Control bit 0 enables the block. While it is 0 the output is 0 in every output mode. On the first enabled clock the head of the queue is loaded, and counting from 0 starts on the next clock.
- R8: The queue holds 4 samples. Status bits [2:0] give the number held.
- R9: A write to the sample register while 4 samples are held is dropped, and status bit 6 is set.
- R10: When a new sample is needed and the queue is empty, the previous sample stays in use and status bit 3 is set.
- R11: Status bit 4 is set on every counter wrap. Status bit 5 is set on any prescaled tick at which the count equals the sample.
- R12: Writing 1 to a status flag bit (3 to 6) clears that flag, unless the same flag is set again in the same clock, in which case it stays set.
- R13: Reading the sample register returns the sample in use while enabled, and 0 while disabled.
- R14: After the reset input every readable register is 0 and the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pwm_out | output | 1 | Modulated output |

## Verification
The embedded properties check on every clock that the queue never exceeds its depth and that a full queue does not grow. They also check that the counter returns to 0 after each wrap, that prescaled ticks are spaced by the divider, that a dry queue keeps the old sample, that a disabled block is unprimed, that the soft reset counts down, and that flags are set and cleared as required. Only the bench's scenarios can show the exact output waveform under each period, divider, repeat and output mode. The same holds for the 0xffff period cap, the ordering of queued samples, and the register read-back values.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
   // word indices of the registers (byte address / 4)
   localparam int unsigned WI_CTRL = 0;
   localparam int unsigned WI_STAT = 1;
   localparam int unsigned WI_SAMP = 3;
   localparam int unsigned WI_PER  = 4;

   // control field positions
   localparam int CB_EN     = 0;
   localparam int CB_REP    = 1;
   localparam int CB_SWR    = 3;
   localparam int CB_DIV    = 4;
   localparam int CB_MODE   = 18;

   // status flag positions
   localparam int SB_FE  = 3;
   localparam int SB_ROV = 4;
   localparam int SB_CMP = 5;
   localparam int SB_FWE = 6;

   localparam logic [31:0] CTRL_KEEP = 32'h0FFF_FFF7;

   typedef enum logic [1:0] {
      OUT_NORMAL = 2'd0,
      OUT_INVERT = 2'd1,
      OUT_HOLD   = 2'd2,
      OUT_HOLD2  = 2'd3
   } out_mode_e;
endpackage

// File: rtl/fpwm_sample_fifo.sv
module fpwm_sample_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);
   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   // R8: occupancy never exceeds the depth
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   // R9: a push into a full queue without a pop leaves it full, never wraps
   p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      full && push && !pop && !clr |=> full);
endmodule

// File: rtl/fpwm_prescaler.sv
module fpwm_prescaler #(
   parameter int PRE_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [PRE_W-1:0] div,
   output logic             tick
);
   logic [PRE_W-1:0] acc;

   assign tick = run && (acc == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             acc <= '0;
      else if (clr || !run)   acc <= '0;
      else if (tick)          acc <= '0;
      else                    acc <= acc + 1'b1;
   end

   // R3: after a tick the next tick needs div further clocks
   p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick && div != '0 |=> (!tick || div == '0));
endmodule

// File: rtl/fpwm_core.sv
module fpwm_core
   import fpwm_pkg::*;
#(
   parameter int DW      = 16,
   parameter int REP_W   = 2,
   parameter bit OUT_REG = 1'b0,
   localparam int RC_W   = (1 << REP_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             tick,
   input  logic [DW-1:0]    period,
   input  logic [REP_W-1:0] rep_sel,
   input  out_mode_e        mode,
   input  logic             fifo_empty,
   input  logic [DW-1:0]    fifo_head,
   output logic             pop,
   output logic             run,
   output logic [DW-1:0]    cur,
   output logic             rov_evt,
   output logic             cmp_evt,
   output logic             fe_evt,
   output logic             pwm_out
);
   localparam logic [DW-1:0] PER_CAP = {{(DW-1){1'b1}}, 1'b0};

   logic            primed;
   logic [DW-1:0]   cnt, peff, last;
   logic [RC_W-1:0] rep, reps_m1;
   logic            at_end, wrap, exhausted, load, below, out_nxt;

   always_comb begin
      reps_m1 = '0;
      for (int i = 0; i < (1 << REP_W); i++) begin
         if (rep_sel == REP_W'(i)) reps_m1 = RC_W'((1 << i) - 1);
      end
   end

   assign peff      = (period > PER_CAP) ? PER_CAP : period;
   assign last      = peff + 1'b1;
   assign run       = en && primed;
   assign at_end    = (cnt >= last);
   assign wrap      = run && tick && at_end;
   assign exhausted = (rep >= reps_m1);
   assign load      = !clr && ((en && !primed) || (wrap && exhausted));
   assign pop       = load && !fifo_empty;
   assign fe_evt    = load && fifo_empty;
   assign rov_evt   = wrap && !clr;
   assign cmp_evt   = run && tick && (cnt == cur) && !clr;
   assign below     = (cnt < cur);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed <= 1'b0;
         cnt    <= '0;
         rep    <= '0;
         cur    <= '0;
      end else if (clr) begin
         primed <= 1'b0;
         cnt    <= '0;
         rep    <= '0;
         cur    <= '0;
      end else if (!en) begin
         primed <= 1'b0;
         cnt    <= '0;
         rep    <= '0;
      end else if (!primed) begin
         primed <= 1'b1;
         rep    <= '0;
         if (!fifo_empty) cur <= fifo_head;
      end else if (tick) begin
         if (at_end) begin
            cnt <= '0;
            if (exhausted) begin
               rep <= '0;
               if (!fifo_empty) cur <= fifo_head;
            end else begin
               rep <= rep + 1'b1;
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   always_comb begin
      unique case (mode)
         OUT_NORMAL: out_nxt = run && below;
         OUT_INVERT: out_nxt = run && !below;
         default:    out_nxt = 1'b0;
      endcase
   end

   generate
      if (OUT_REG) begin : g_out_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   pwm_out <= 1'b0;
            else if (clr) pwm_out <= 1'b0;
            else          pwm_out <= out_nxt;
         end
      end else begin : g_out_comb
         assign pwm_out = out_nxt;
      end
   endgenerate

   // R2: the counter restarts from 0 after every wrap
   p_wrap_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rov_evt |=> cnt == '0);
   // R10: running dry keeps the previous sample
   p_hold_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fe_evt |=> cur == $past(cur));
   // R7: a disabled block drops its primed state on the next clock
   p_idle_unprimed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !primed);
endmodule

// File: rtl/fifo_pwm.sv
module fifo_pwm
   import fpwm_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int DW         = 16,
   parameter int DEPTH      = 4,
   parameter int PRE_W      = 12,
   parameter int SWR_CYCLES = 3,
   parameter bit OUT_REG    = 1'b0,
   localparam int CW        = $clog2(DEPTH + 1),
   localparam int SW_W      = $clog2(SWR_CYCLES + 1),
   localparam int WI_W      = ADDR_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              pwm_out
);
   generate
      if (DEPTH < 2 || DEPTH > 7) begin : g_bad_depth
         $error("fifo_pwm: DEPTH must lie in 2..7 to fit the level field");
      end
      if (DW < 2 || DW > 16) begin : g_bad_dw
         $error("fifo_pwm: DW must lie in 2..16");
      end
      if (PRE_W < 1 || PRE_W > 12) begin : g_bad_pre
         $error("fifo_pwm: PRE_W must lie in 1..12");
      end
      if (SWR_CYCLES < 1) begin : g_bad_swr
         $error("fifo_pwm: SWR_CYCLES must be at least 1");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("fifo_pwm: ADDR_W must be at least 5");
      end
   endgenerate

   logic [31:0]     ctrl_q;
   logic [DW-1:0]   period_q;
   logic [SW_W-1:0] swr_cnt;
   logic            busy, acc_ok, wr_ok, swr_go;
   logic [WI_W-1:0] word;
   logic            wr_ctrl, wr_stat, wr_samp, wr_per;
   logic            flag_fwe, flag_cmp, flag_rov, flag_fe;

   logic [DW-1:0]   fifo_head, cur;
   logic [CW-1:0]   fifo_count;
   logic            fifo_empty, fifo_full, pop, run, tick;
   logic            rov_evt, cmp_evt, fe_evt;
   logic            en;
   out_mode_e       mode;

   assign busy    = (swr_cnt != '0);
   assign word    = bus_addr[ADDR_W-1:2];
   assign acc_ok  = bus_sel && (bus_addr[1:0] == 2'b00);
   assign wr_ok   = acc_ok && bus_wr && !busy;
   assign wr_ctrl = wr_ok && (word == WI_W'(WI_CTRL));
   assign wr_stat = wr_ok && (word == WI_W'(WI_STAT));
   assign wr_samp = wr_ok && (word == WI_W'(WI_SAMP));
   assign wr_per  = wr_ok && (word == WI_W'(WI_PER));
   assign swr_go  = wr_ctrl && bus_wdata[CB_SWR];

   assign en   = ctrl_q[CB_EN];
   assign mode = out_mode_e'(ctrl_q[CB_MODE +: 2]);

   // control, period and soft-reset sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         period_q <= '0;
         swr_cnt  <= '0;
      end else if (swr_go) begin
         ctrl_q   <= '0;
         period_q <= '0;
         swr_cnt  <= SW_W'(SWR_CYCLES);
      end else if (busy) begin
         swr_cnt  <= swr_cnt - 1'b1;
      end else begin
         if (wr_ctrl) ctrl_q   <= bus_wdata & CTRL_KEEP;
         if (wr_per)  period_q <= bus_wdata[DW-1:0];
      end
   end

   // sticky flags, cleared by writing 1, a new event wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_fwe <= 1'b0;
         flag_cmp <= 1'b0;
         flag_rov <= 1'b0;
         flag_fe  <= 1'b0;
      end else if (swr_go) begin
         flag_fwe <= 1'b0;
         flag_cmp <= 1'b0;
         flag_rov <= 1'b0;
         flag_fe  <= 1'b0;
      end else begin
         flag_fwe <= (wr_samp && fifo_full) || (flag_fwe && !(wr_stat && bus_wdata[SB_FWE]));
         flag_cmp <= cmp_evt || (flag_cmp && !(wr_stat && bus_wdata[SB_CMP]));
         flag_rov <= rov_evt || (flag_rov && !(wr_stat && bus_wdata[SB_ROV]));
         flag_fe  <= fe_evt  || (flag_fe  && !(wr_stat && bus_wdata[SB_FE]));
      end
   end

   fpwm_sample_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (swr_go),
      .push  (wr_samp),
      .pop   (pop),
      .din   (bus_wdata[DW-1:0]),
      .head  (fifo_head),
      .count (fifo_count),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   fpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (swr_go),
      .run   (run),
      .div   (ctrl_q[CB_DIV +: PRE_W]),
      .tick  (tick)
   );

   fpwm_core #(.DW(DW), .REP_W(2), .OUT_REG(OUT_REG)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (swr_go),
      .en         (en),
      .tick       (tick),
      .period     (period_q),
      .rep_sel    (ctrl_q[CB_REP +: 2]),
      .mode       (mode),
      .fifo_empty (fifo_empty),
      .fifo_head  (fifo_head),
      .pop        (pop),
      .run        (run),
      .cur        (cur),
      .rov_evt    (rov_evt),
      .cmp_evt    (cmp_evt),
      .fe_evt     (fe_evt),
      .pwm_out    (pwm_out)
   );

   // register read mux
   always_comb begin
      bus_rdata = '0;
      if (acc_ok) begin
         case (word)
            WI_W'(WI_CTRL): bus_rdata = ctrl_q | (32'(busy) << CB_SWR);
            WI_W'(WI_STAT): bus_rdata = {25'd0, flag_fwe, flag_cmp, flag_rov,
                                         flag_fe, 3'(fifo_count)};
            WI_W'(WI_SAMP): bus_rdata = en ? 32'(cur) : 32'd0;
            WI_W'(WI_PER):  bus_rdata = 32'(period_q);
            default:        bus_rdata = '0;
         endcase
      end
   end

   // R6: the soft-reset countdown falls by one each busy clock
   p_swr_selfclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> swr_cnt == SW_W'($past(swr_cnt) - 1'b1));
   // R9: a sample write into a full queue raises the write-error flag
   p_fwe_on_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_samp && fifo_full |=> flag_fwe);
   // R12: writing 1 clears the wrap flag when no wrap happens that clock
   p_w1c_r12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat && bus_wdata[SB_ROV] && !rov_evt |=> !flag_rov);
endmodule

// File: tb/sim_fifo_pwm.sv
module sim_fifo_pwm;
   localparam int SWR = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic        wr = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   wire  [31:0] rdata;
   wire         pout;

   always #4 clk = ~clk;

   fifo_pwm u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (sel),
      .bus_wr    (wr),
      .bus_addr  (addr),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .pwm_out   (pout)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   string phase = "R14";
   logic [31:0] rv;

   // behavioural reference state
   int m_ctrl = 0, m_per = 0, m_cur = 0, m_rep = 0, m_cnt = 0, m_pre = 0, m_swr = 0;
   bit m_primed = 0, m_fwe = 0, m_cmp = 0, m_rov = 0, m_fe = 0;
   int m_q[$];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic bit m_out();
      bit run = ((m_ctrl & 1) != 0) && m_primed;
      bit lt  = m_cnt < m_cur;
      int md  = (m_ctrl >> 18) & 3;
      if (md == 0) return run && lt;
      if (md == 1) return run && !lt;
      return 1'b0;
   endfunction

   function automatic logic [31:0] m_read(int w);
      case (w)
         0: return 32'(m_ctrl | ((m_swr != 0) ? 8 : 0));
         1: return 32'((int'(m_fwe) << 6) | (int'(m_cmp) << 5) | (int'(m_rov) << 4) |
                       (int'(m_fe) << 3) | m_q.size());
         3: return ((m_ctrl & 1) != 0) ? 32'(m_cur) : 32'd0;
         4: return 32'(m_per);
         default: return 32'd0;
      endcase
   endfunction

   task automatic m_clear();
      m_ctrl = 0; m_per = 0; m_cur = 0; m_rep = 0; m_cnt = 0; m_pre = 0;
      m_primed = 0; m_fwe = 0; m_cmp = 0; m_rov = 0; m_fe = 0;
      m_q.delete();
   endtask

   task automatic m_step();
      bit w = sel && wr && (addr[1:0] == 2'b00);
      int word = int'(addr >> 2);
      bit en = (m_ctrl & 1) != 0;
      bit full_old = m_q.size() >= 4;
      bit nonempty = m_q.size() > 0;
      int head = nonempty ? m_q[0] : 0;
      bit pop = 0, s_rov = 0, s_cmp = 0, s_fe = 0, s_fwe = 0;
      bit c_stat = w && word == 1;
      if (m_swr != 0) begin
         m_swr--;
         return;
      end
      if (w && word == 0 && wdata[3]) begin
         m_clear();
         m_swr = SWR;
         return;
      end
      if (!en) begin
         m_primed = 0; m_cnt = 0; m_pre = 0; m_rep = 0;
      end else if (!m_primed) begin
         m_primed = 1; m_rep = 0;
         if (nonempty) begin pop = 1; m_cur = head; end
         else s_fe = 1;
      end else begin
         int dv = (m_ctrl >> 4) & 'hfff;
         bit tick = (m_pre == dv);
         m_pre = tick ? 0 : ((m_pre + 1) & 'hfff);
         if (tick) begin
            int peff = (m_per > 'hfffe) ? 'hfffe : m_per;
            if (m_cnt == m_cur) s_cmp = 1;
            if (m_cnt >= peff + 1) begin
               int reps = 1 << ((m_ctrl >> 1) & 3);
               s_rov = 1;
               m_cnt = 0;
               if (m_rep >= reps - 1) begin
                  m_rep = 0;
                  if (nonempty) begin pop = 1; m_cur = head; end
                  else s_fe = 1;
               end else m_rep++;
            end else m_cnt++;
         end
      end
      if (pop) void'(m_q.pop_front());
      if (w && word == 3) begin
         if (full_old) s_fwe = 1;
         else m_q.push_back(int'(wdata & 32'hffff));
      end
      if (w && word == 0) m_ctrl = int'(wdata & 32'h0FFF_FFF7);
      if (w && word == 4) m_per = int'(wdata & 32'hffff);
      m_fwe = s_fwe || (m_fwe && !(c_stat && wdata[6]));
      m_cmp = s_cmp || (m_cmp && !(c_stat && wdata[5]));
      m_rov = s_rov || (m_rov && !(c_stat && wdata[4]));
      m_fe  = s_fe  || (m_fe  && !(c_stat && wdata[3]));
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_clear();
         m_swr = 0;
      end else m_step();
   end

   // output compared against the model on every clock
   always @(negedge clk) begin
      if (!done) chk(phase, 32'(pout), 32'(m_out()));
   end

   task automatic wr_reg(int word, logic [31:0] d);
      @(negedge clk);
      sel = 1; wr = 1; addr = 5'(word * 4); wdata = d;
      @(negedge clk);
      sel = 0; wr = 0; wdata = '0;
   endtask

   task automatic rd_reg(int word, string req);
      @(negedge clk);
      sel = 1; wr = 0; addr = 5'(word * 4);
      #1;
      rv = rdata;
      chk(req, rdata, m_read(word));
      sel = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R14 reset state, R1 map including unmapped word 2
      for (int w = 0; w < 5; w++) begin
         rd_reg(w, "R14");
         chk("R14", rv, 32'd0);
      end
      rd_reg(2, "R1");

      // R8 fill, R9 overflow, R12 clear
      phase = "R8";
      wr_reg(4, 32'd3);
      rd_reg(4, "R1");
      chk("R1", rv, 32'd3);
      for (int i = 1; i <= 4; i++) wr_reg(3, 32'(i));
      rd_reg(1, "R8");
      chk("R8", 32'(rv[2:0]), 32'd4);
      wr_reg(3, 32'd5);
      rd_reg(1, "R9");
      chk("R9", 32'(rv[6]), 32'd1);
      chk("R9", 32'(rv[2:0]), 32'd4);
      wr_reg(1, 32'h40);
      rd_reg(1, "R12");
      chk("R12", 32'(rv[6]), 32'd0);

      // R7 enable, R2 period of 5 ticks, R4 normal output
      phase = "R2";
      wr_reg(0, 32'h1);
      idle(12);
      rd_reg(3, "R13");
      idle(20);
      // R10 queue ran dry, R11 flags
      phase = "R10";
      rd_reg(1, "R10");
      chk("R10", 32'(rv[3]), 32'd1);
      chk("R11", 32'(rv[5:4]), 32'd3);
      rd_reg(3, "R10");
      chk("R10", rv, 32'd4);
      wr_reg(1, 32'h78);
      rd_reg(1, "R12");

      // R3 divider 3, R5 repeat twice, R4 inverted
      phase = "R5";
      wr_reg(0, 32'h1 | (32'd1 << 1) | (32'd2 << 4) | (32'd1 << 18));
      wr_reg(3, 32'd2);
      wr_reg(3, 32'd1);
      idle(40);
      rd_reg(3, "R3");
      idle(40);
      // R5 repeat eight times with divider 1
      wr_reg(3, 32'd3);
      wr_reg(0, 32'h1 | (32'd3 << 1));
      idle(60);
      rd_reg(1, "R5");
      // R4 held off
      phase = "R4";
      wr_reg(0, 32'h1 | (32'd2 << 18));
      idle(15);
      wr_reg(0, 32'h1 | (32'd3 << 18));
      idle(10);

      // R7 disable with other bits set, R13 sample reads 0, R1 read-back
      phase = "R7";
      wr_reg(0, 32'hFF35_5AA6);
      idle(3);
      rd_reg(0, "R1");
      chk("R1", rv, 32'h0F35_5AA6);
      rd_reg(3, "R13");
      chk("R13", rv, 32'd0);
      idle(5);

      // R2 period cap: 0xffff acts as 0xfffe
      phase = "R2";
      wr_reg(0, 32'h0);
      wr_reg(3, 32'h8000);
      wr_reg(4, 32'hffff);
      rd_reg(4, "R1");
      chk("R1", rv, 32'h0000_ffff);
      wr_reg(0, 32'h1);
      wr_reg(1, 32'h78);
      idle(65520);
      rd_reg(1, "R2");
      idle(40);
      rd_reg(1, "R11");
      chk("R11", 32'(rv[4]), 32'd1);

      // R6 soft reset
      phase = "R6";
      wr_reg(3, 32'd7);
      wr_reg(0, 32'h9);
      rd_reg(0, "R6");
      chk("R6", rv, 32'h8);
      wr_reg(4, 32'h55);
      idle(4);
      for (int w = 0; w < 5; w++) begin
         rd_reg(w, "R6");
         chk("R6", rv, 32'd0);
      end
      wr_reg(4, 32'h2);
      rd_reg(4, "R6");
      idle(2);
      finish_run();
   end
endmodule